// File: doc/BRIEF.md
# SIMT Lane Mask Stack

This block tracks which lanes of a 16-lane SIMD thread may commit results while the thread runs through nested if/else regions. Every lane executes both sides of a divergent branch; the active mask produced here decides which lanes write back. The instruction decoder supplies a per-lane predicate bit, produced earlier by a compare, along with three markers. A push enters a conditional region. A complement switches to the else side. A pop leaves the region at the reconvergence point.

A push saves the current mask on an internal stack. The new mask keeps only the lanes that were active and whose predicate is set. A complement selects the lanes that were active at the matching push but were not on the then side. A pop restores the saved mask. The stack is eight entries deep. Misuse is reported through two error pulses and leaves the state untouched.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset, `active_o` is all ones, `depth_o` is 0, and `ovf_o` and `unf_o` are low.
- R2: A push on a non-full stack saves the current mask as the new top entry. In the next cycle `active_o` equals the previous `active_o` AND `pred_i`, and `depth_o` has grown by one.
- R3: A complement on a non-empty stack sets `active_o` to the top entry AND NOT the previous `active_o`, and leaves `depth_o` unchanged.
- R4: A pop on a non-empty stack sets `active_o` to the top entry and lowers `depth_o` by one.
- R5: Nested pushes are undone in last-in, first-out order, so each pop restores the mask that was current just before the matching push.
- R6: A push while `depth_o` is 8 sets `ovf_o` high for exactly the next cycle. The mask, the depth and the stored entries stay unchanged.
- R7: A pop or a complement while `depth_o` is 0 sets `unf_o` high for exactly the next cycle, and the mask and depth stay unchanged.
- R8: When several markers are asserted in the same cycle, pop takes precedence over complement, and complement takes precedence over push. Only the winning marker takes effect.
- R9: `pred_i` has no effect in cycles without a push, and both error flags are low in the cycle after any legal marker or idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_i | input | 16 | Per-lane predicate bits |
| push_i | input | 1 | Enter a divergent region |
| comp_i | input | 1 | Switch to the else side |
| pop_i | input | 1 | Reconverge and restore the mask |
| active_o | output | 16 | Lanes allowed to commit |
| depth_o | output | 4 | Number of saved masks |
| ovf_o | output | 1 | Push on full stack, one-cycle pulse |
| unf_o | output | 1 | Pop or complement on empty stack, one-cycle pulse |

## Verification
The bench drives nesting down to the full depth of eight. It then pops back to empty and compares every restored mask. A design with a wrong stack index, or one that writes on an overflowing push, would return corrupted masks during this unwind. Complement is applied from a partial mask. A design that only inverted the current mask would turn on lanes that were off before the push. Conflicting markers in the same cycle and a predicate that changes with no marker present are also applied. A design that got these wrong would show the wrong mask or the wrong depth, or raise a flag where none should appear.

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES = 16,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] pred_i,
  input  logic             push_i,
  input  logic             comp_i,
  input  logic             pop_i,
  output logic [LANES-1:0] active_o,
  output logic [DW-1:0]    depth_o,
  output logic             ovf_o,
  output logic             unf_o
);

  logic [LANES-1:0] stk [DEPTH];
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    depth_q;

  wire full  = depth_q == DW'(DEPTH);
  wire empty = depth_q == '0;
  wire [AW-1:0] top_idx = AW'(depth_q - 1'b1);
  wire [AW-1:0] wr_idx  = AW'(depth_q);
  wire [LANES-1:0] top = stk[top_idx];

  wire do_pop  = pop_i && !empty;
  wire do_comp = comp_i && !pop_i && !empty;
  wire do_push = push_i && !pop_i && !comp_i && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      depth_q <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      ovf_o <= push_i && !pop_i && !comp_i && full;
      unf_o <= (pop_i || comp_i) && empty;
      if (do_pop) begin
        mask_q  <= top;
        depth_q <= depth_q - 1'b1;
      end else if (do_comp) begin
        mask_q  <= top & ~mask_q;
      end else if (do_push) begin
        mask_q  <= mask_q & pred_i;
        depth_q <= depth_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (rst_n && do_push) stk[wr_idx] <= mask_q;

  assign active_o = mask_q;
  assign depth_o  = depth_q;

endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
  parameter int LANES = 16,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] pred_i,
  input logic             push_i,
  input logic             comp_i,
  input logic             pop_i,
  input logic [LANES-1:0] active_o,
  input logic [DW-1:0]    depth_o,
  input logic             ovf_o,
  input logic             unf_o
);

  wire full  = depth_o == DW'(DEPTH);
  wire empty = depth_o == '0;

  // R2
  push_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !comp_i && !pop_i && !full) |=>
      (active_o == $past(active_o & pred_i)) && (depth_o == $past(depth_o) + 1'b1));

  // R3
  comp_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_i && !pop_i && !empty) |=>
      ((active_o & $past(active_o)) == '0) && $stable(depth_o));

  // R4
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty) |=> (depth_o == $past(depth_o) - 1'b1));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !comp_i && !pop_i && full) |=>
      ovf_o && $stable(active_o) && $stable(depth_o));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pop_i || comp_i) && empty) |=> unf_o && $stable(active_o) && $stable(depth_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !comp_i && !pop_i) |=>
      $stable(active_o) && $stable(depth_o) && !ovf_o && !unf_o);

  // R9
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_o, unf_o}));

  // R6
  depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= DW'(DEPTH));

endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_i(pred_i), .push_i(push_i), .comp_i(comp_i),
  .pop_i(pop_i), .active_o(active_o), .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/test_simt_mask_stack.sv
`timescale 1ns/1ps
module test_simt_mask_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pred_i = '0;
  logic        push_i = 1'b0, comp_i = 1'b0, pop_i = 1'b0;
  logic [15:0] active_o;
  logic [3:0]  depth_o;
  logic        ovf_o, unf_o;

  int checks = 0, fails = 0;
  logic [15:0] m_mask;
  logic [15:0] m_stk [8];
  int          m_depth;

  always #4 clk = ~clk;

  simt_mask_stack i_simt_mask_stack (
    .clk(clk), .rst_n(rst_n), .pred_i(pred_i), .push_i(push_i), .comp_i(comp_i),
    .pop_i(pop_i), .active_o(active_o), .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag, bit e_ovf, bit e_unf);
    chk(tag, "active", 32'(active_o), 32'(m_mask));
    chk(tag, "depth", 32'(depth_o), 32'(m_depth));
    chk(tag, "ovf", 32'(ovf_o), 32'(e_ovf));
    chk(tag, "unf", 32'(unf_o), 32'(e_unf));
  endtask

  task automatic step(string tag, bit pu, bit co, bit po, logic [15:0] pr);
    bit e_ovf = 1'b0, e_unf = 1'b0;
    push_i = pu; comp_i = co; pop_i = po; pred_i = pr;
    if (po) begin
      if (m_depth == 0) e_unf = 1'b1;
      else begin m_mask = m_stk[m_depth-1]; m_depth--; end
    end else if (co) begin
      if (m_depth == 0) e_unf = 1'b1;
      else m_mask = m_stk[m_depth-1] & ~m_mask;
    end else if (pu) begin
      if (m_depth == 8) e_ovf = 1'b1;
      else begin m_stk[m_depth] = m_mask; m_mask = m_mask & pr; m_depth++; end
    end
    @(negedge clk);
    push_i = 1'b0; comp_i = 1'b0; pop_i = 1'b0;
    check_all(tag, e_ovf, e_unf);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_mask = '1; m_depth = 0;
    check_all("R1", 1'b0, 1'b0);
  endtask

  task automatic t_basic_if_else();
    step("R2", 1, 0, 0, 16'h0F0F);
    step("R3", 0, 1, 0, 16'hFFFF);
    step("R4", 0, 0, 1, 16'h0000);
  endtask

  task automatic t_partial_complement();
    step("R2", 1, 0, 0, 16'h00FF);
    step("R2", 1, 0, 0, 16'h0033);
    step("R3", 0, 1, 0, 16'h0000);
    chk("R3", "else lanes inside outer", 32'(active_o), 32'h00CC);
    step("R4", 0, 0, 1, 16'h0000);
    step("R4", 0, 0, 1, 16'h0000);
  endtask

  task automatic t_nest_and_overflow();
    logic [15:0] pats [8] = '{16'hFFFE, 16'h7FFF, 16'hF0FF, 16'hAAAB,
                              16'hFFF7, 16'h3FFF, 16'hEEEF, 16'hDFFF};
    for (int i = 0; i < 8; i++) step("R5", 1, 0, 0, pats[i]);
    step("R6", 1, 0, 0, 16'h0000);
    step("R6", 1, 0, 0, 16'hFFFF);
    for (int i = 0; i < 8; i++) step("R5", 0, 0, 1, 16'h0000);
    chk("R5", "fully unwound", 32'(active_o), 32'hFFFF);
  endtask

  task automatic t_underflow();
    step("R7", 0, 0, 1, 16'h1234);
    step("R7", 0, 1, 0, 16'h1234);
    step("R9", 0, 0, 0, 16'h0000);
  endtask

  task automatic t_priority();
    step("R2", 1, 0, 0, 16'h0FF0);
    step("R8", 1, 1, 0, 16'h0000);
    step("R8", 1, 1, 1, 16'h0000);
    step("R2", 1, 0, 0, 16'h0F00);
    step("R8", 1, 0, 1, 16'h0000);
    step("R4", 0, 0, 1, 16'h0000);
  endtask

  task automatic t_pred_ignored();
    step("R2", 1, 0, 0, 16'h5555);
    step("R9", 0, 0, 0, 16'h0000);
    step("R9", 0, 0, 0, 16'hAAAA);
    step("R4", 0, 0, 1, 16'h0000);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_basic_if_else();
    t_partial_complement();
    t_nest_and_overflow();
    t_underflow();
    t_priority();
    t_pred_ignored();
    do_reset();
    finish_run();
  end
endmodule